// File: doc/BRIEF.md
# Unfiltered Texel Fetch Address Checker

This block sits between a shader core and a texel memory and serves integer-addressed texel reads that bypass filtering. Each request carries a resource kind, a four-component unsigned address (x, y, z, w) and the descriptor of the resource: base width, height, depth, layer count, number of mip levels and one base address per mip level. The block decides which address components are meaningful for that kind, shrinks the extents to the selected mip level, and checks every used component against its limit.

If all checks pass, it forms a linear texel address and issues a single read on a synchronous memory port. The texel comes back two cycles after the request. If any check fails, no read is issued and the response is all zeros. Coordinates are never wrapped. Cube resources are rejected with an error flag. The block accepts one request per cycle and returns responses in request order.

Top module: `texel_fetch_unit`

## Requirements
- R1: Kind code 0 (buffer) range-checks only x against the base width and reads from level-0 base + x. Components y, z and w have no effect on it.
- R2: Kind code 1 (1D) checks x against the mip-scaled width and reads level_base[w] + x. Components y and z are ignored.
- R3: Kind codes 2 (2D) and 4 (rectangle) read level_base[w] + y*w_l + x, with x < w_l and y < h_l. Component z is ignored.
- R4: Kind code 3 (3D) reads level_base[w] + (z*h_l + y)*w_l + x, with z also checked against the mip-scaled depth.
- R5: Kind code 6 (1D array) uses y as the layer index. The layer index is checked against the layer count, which is not mip-scaled. The read address is level_base[w] + y*w_l + x, and z is ignored.
- R6: Kind code 7 (2D array) uses z as the layer index against the unscaled layer count. The read address is level_base[w] + (z*h_l + y)*w_l + x.
- R7: The extent of an axis at level l is its base extent shifted right by l, and never less than 1.
- R8: For every kind except buffer, a w value at or above the mip level count returns zero data and issues no memory read.
- R9: Any used coordinate or layer index at or beyond its limit returns zero data and issues no memory read. A memory read is issued only in a cycle that carries a request.
- R10: Kind code 5 (cube) issues no read and returns zero data with rsp_err set. Every other kind returns rsp_err clear.
- R11: A request accepted in cycle n is answered with rsp_valid in cycle n+2. Back-to-back requests give back-to-back responses in order.
- R12: While reset is held low, rsp_valid, rsp_err and mem_rd_en are low and rsp_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request strobe |
| req_kind | input | 3 | Resource kind code |
| addr_x | input | COORD_W | Address component x |
| addr_y | input | COORD_W | Address component y |
| addr_z | input | COORD_W | Address component z |
| addr_w | input | COORD_W | Address component w (mip level) |
| desc_width | input | COORD_W | Base width in texels |
| desc_height | input | COORD_W | Base height in texels |
| desc_depth | input | COORD_W | Base depth in texels |
| desc_layers | input | COORD_W | Array layer count |
| desc_levels | input | $clog2(MAX_LEVELS+1) | Number of mip levels present |
| desc_level_base | input | MAX_LEVELS*ADDR_W | Base address of each level, level 0 in the low bits |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Read data, valid the cycle after mem_rd_en |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | DATA_W | Texel, or zero when rejected |
| rsp_err | output | 1 | Request named a cube resource |

## Verification
The bench builds the block with its defaults: 12-bit coordinates, 20-bit addresses, 32-bit texels and room for four mip levels. The descriptor declares only three levels, so level 3 is a legal index into the base table but lies beyond the level count, which exercises the level check apart from table bounds. A 10x6x5 base size reaches the one-texel floor at level 2. The memory model returns a word tagged with the address it was given, so every returned texel also confirms the computed address.

// File: rtl/texfetch_pkg.sv
// Shared definitions for the texel fetch path.
// Assumes resource kinds fit in three bits; the codes are part of the port contract.
package texfetch_pkg;

    typedef enum logic [2:0] {
        KIND_BUFFER    = 3'd0,
        KIND_LINE      = 3'd1,
        KIND_PLANE     = 3'd2,
        KIND_VOLUME    = 3'd3,
        KIND_RECT      = 3'd4,
        KIND_CUBE      = 3'd5,
        KIND_LINE_ARR  = 3'd6,
        KIND_PLANE_ARR = 3'd7
    } res_kind_e;

endpackage

// File: rtl/texfetch_level_scale.sv
// Reduces one base extent to its size at a mip level: base >> level, floored at 1.
// Assumes level is below COORD_W so the shift is meaningful.
module texfetch_level_scale #(
    parameter int COORD_W = 12,
    parameter int LVL_W   = 2
) (
    input  logic [COORD_W-1:0] base_extent,
    input  logic [LVL_W-1:0]   level,
    output logic [COORD_W-1:0] level_extent
);

    logic [COORD_W-1:0] shifted;

    // Shift and apply the one-texel floor.
    always_comb begin
        shifted      = base_extent >> level;
        level_extent = (shifted == '0) ? COORD_W'(1) : shifted;
    end

endmodule

// File: rtl/texfetch_coord_sel.sv
// Chooses which address components act as column, row and slice for a resource
// kind, sets the limit each is checked against, and reports whether all fit.
// Unused axes get coordinate 0 and limit 1 so they always pass.
// Assumes extents are already scaled to the selected mip level.
module texfetch_coord_sel
    import texfetch_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic [2:0]         kind,
    input  logic [COORD_W-1:0] ax,
    input  logic [COORD_W-1:0] ay,
    input  logic [COORD_W-1:0] az,
    input  logic [COORD_W-1:0] w_lvl,
    input  logic [COORD_W-1:0] h_lvl,
    input  logic [COORD_W-1:0] d_lvl,
    input  logic [COORD_W-1:0] layers,
    output logic [COORD_W-1:0] col,
    output logic [COORD_W-1:0] row,
    output logic [COORD_W-1:0] slice,
    output logic [COORD_W-1:0] row_pitch_rows,
    output logic               is_cube,
    output logic               coords_ok
);

    logic [COORD_W-1:0] lim_row;
    logic [COORD_W-1:0] lim_slice;

    // Per-kind mapping of address components onto the three memory axes.
    always_comb begin
        col            = ax;
        row            = '0;
        slice          = '0;
        lim_row        = COORD_W'(1);
        lim_slice      = COORD_W'(1);
        row_pitch_rows = COORD_W'(1);
        is_cube        = 1'b0;
        unique case (res_kind_e'(kind))
            KIND_BUFFER, KIND_LINE: ;
            KIND_PLANE, KIND_RECT: begin
                row            = ay;
                lim_row        = h_lvl;
                row_pitch_rows = h_lvl;
            end
            KIND_VOLUME: begin
                row            = ay;
                slice          = az;
                lim_row        = h_lvl;
                lim_slice      = d_lvl;
                row_pitch_rows = h_lvl;
            end
            KIND_LINE_ARR: begin
                slice     = ay;
                lim_slice = layers;
            end
            KIND_PLANE_ARR: begin
                row            = ay;
                slice          = az;
                lim_row        = h_lvl;
                lim_slice      = layers;
                row_pitch_rows = h_lvl;
            end
            default: is_cube = 1'b1;
        endcase
    end

    // All used axes must lie inside their limits; cube never passes.
    always_comb begin
        coords_ok = !is_cube && (col < w_lvl) && (row < lim_row) && (slice < lim_slice);
    end

endmodule

// File: rtl/texfetch_addr_gen.sv
// Linear texel address: level base + (slice*rows + row)*width + col.
// Assumes the result fits ADDR_W; upper bits are dropped otherwise.
module texfetch_addr_gen #(
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 20
) (
    input  logic [ADDR_W-1:0]  level_base,
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] row,
    input  logic [COORD_W-1:0] slice,
    input  logic [COORD_W-1:0] rows,
    input  logic [COORD_W-1:0] width,
    output logic [ADDR_W-1:0]  texel_addr
);

    logic [ADDR_W-1:0] row_index;

    // Row index across slices, then scale by width and add the column.
    always_comb begin
        row_index  = ADDR_W'(slice) * ADDR_W'(rows) + ADDR_W'(row);
        texel_addr = level_base + row_index * ADDR_W'(width) + ADDR_W'(col);
    end

endmodule

// File: rtl/texel_fetch_unit.sv
// Unfiltered texel fetch with range checking.
// Decodes the resource kind, scales extents to the requested mip level, checks
// every used component, and issues one memory read when all pass. The memory
// returns data one cycle after the read; the response is registered, giving a
// two-cycle request-to-response latency. Rejected and cube requests do not read
// memory and answer with zeros. Assumes MAX_LEVELS >= 2 and in-order memory.
module texel_fetch_unit
    import texfetch_pkg::*;
#(
    parameter int COORD_W    = 12,
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 32,
    parameter int MAX_LEVELS = 4,
    localparam int LVL_W     = $clog2(MAX_LEVELS),
    localparam int LCNT_W    = $clog2(MAX_LEVELS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [2:0]                   req_kind,
    input  logic [COORD_W-1:0]           addr_x,
    input  logic [COORD_W-1:0]           addr_y,
    input  logic [COORD_W-1:0]           addr_z,
    input  logic [COORD_W-1:0]           addr_w,
    input  logic [COORD_W-1:0]           desc_width,
    input  logic [COORD_W-1:0]           desc_height,
    input  logic [COORD_W-1:0]           desc_depth,
    input  logic [COORD_W-1:0]           desc_layers,
    input  logic [LCNT_W-1:0]            desc_levels,
    input  logic [MAX_LEVELS*ADDR_W-1:0] desc_level_base,
    output logic                         mem_rd_en,
    output logic [ADDR_W-1:0]            mem_rd_addr,
    input  logic [DATA_W-1:0]            mem_rd_data,
    output logic                         rsp_valid,
    output logic [DATA_W-1:0]            rsp_data,
    output logic                         rsp_err
);

    localparam int NUM_AXES = 3;

    logic               level_used;
    logic               level_ok;
    logic [LVL_W-1:0]   level_idx;
    logic [COORD_W-1:0] base_ext [NUM_AXES];
    logic [COORD_W-1:0] lvl_ext  [NUM_AXES];
    logic [ADDR_W-1:0]  level_base;
    logic [COORD_W-1:0] col, row, slice, rows;
    logic               is_cube;
    logic               coords_ok;
    logic [ADDR_W-1:0]  texel_addr;
    logic               s1_valid, s1_ok, s1_err;

    // Level check: buffers ignore w; others need w below both the count and table size.
    always_comb begin
        level_used = (req_kind != KIND_BUFFER);
        level_ok   = !level_used ||
                     ((addr_w < COORD_W'(desc_levels)) && (addr_w < COORD_W'(MAX_LEVELS)));
        level_idx  = (level_used && level_ok) ? addr_w[LVL_W-1:0] : '0;
        level_base = desc_level_base[level_idx*ADDR_W +: ADDR_W];
    end

    // Gather the base extents so each axis can be scaled by the same unit.
    always_comb begin
        base_ext[0] = desc_width;
        base_ext[1] = desc_height;
        base_ext[2] = desc_depth;
    end

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        texfetch_level_scale #(
            .COORD_W(COORD_W),
            .LVL_W  (LVL_W)
        ) u_scale (
            .base_extent (base_ext[a]),
            .level       (level_idx),
            .level_extent(lvl_ext[a])
        );
    end

    texfetch_coord_sel #(
        .COORD_W(COORD_W)
    ) u_sel (
        .kind          (req_kind),
        .ax            (addr_x),
        .ay            (addr_y),
        .az            (addr_z),
        .w_lvl         (lvl_ext[0]),
        .h_lvl         (lvl_ext[1]),
        .d_lvl         (lvl_ext[2]),
        .layers        (desc_layers),
        .col           (col),
        .row           (row),
        .slice         (slice),
        .row_pitch_rows(rows),
        .is_cube       (is_cube),
        .coords_ok     (coords_ok)
    );

    texfetch_addr_gen #(
        .COORD_W(COORD_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .level_base(level_base),
        .col       (col),
        .row       (row),
        .slice     (slice),
        .rows      (rows),
        .width     (lvl_ext[0]),
        .texel_addr(texel_addr)
    );

    // Read strobe: only for a live request that passed every check.
    always_comb begin
        mem_rd_en   = rst_n && req_valid && coords_ok && level_ok;
        mem_rd_addr = texel_addr;
    end

    // Stage 1: remember what the in-flight request expects from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_ok    <= 1'b0;
            s1_err   <= 1'b0;
        end else begin
            s1_valid <= req_valid;
            s1_ok    <= req_valid && coords_ok && level_ok;
            s1_err   <= req_valid && is_cube;
        end
    end

    // Stage 2: register the response, zeroing data for rejected requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_data  <= s1_ok ? mem_rd_data : '0;
            rsp_err   <= s1_err;
        end
    end

endmodule

// File: rtl/texfetch_checker.sv
// Protocol checks for texel_fetch_unit, attached by bind.
module texfetch_checker #(
    parameter int COORD_W    = 12,
    parameter int DATA_W     = 32,
    parameter int MAX_LEVELS = 4,
    localparam int LCNT_W    = $clog2(MAX_LEVELS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [2:0]         req_kind,
    input logic [COORD_W-1:0] addr_w,
    input logic [LCNT_W-1:0]  desc_levels,
    input logic               mem_rd_en,
    input logic               rsp_valid,
    input logic [DATA_W-1:0]  rsp_data,
    input logic               rsp_err
);

    assert_rsp_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 rsp_valid);

    assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));

    assert_read_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> req_valid);

    assert_cube_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd5) |-> !mem_rd_en);

    assert_cube_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd5) |-> ##2 (rsp_valid && rsp_err));

    assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == '0));

    assert_level_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 3'd0 && addr_w >= COORD_W'(desc_levels)) |-> !mem_rd_en);

endmodule

bind texel_fetch_unit texfetch_checker #(
    .COORD_W   (COORD_W),
    .DATA_W    (DATA_W),
    .MAX_LEVELS(MAX_LEVELS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .addr_w     (addr_w),
    .desc_levels(desc_levels),
    .mem_rd_en  (mem_rd_en),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_err    (rsp_err)
);

// File: tb/texel_fetch_unit_tb.sv
// Scoreboard bench: the driver queues expected responses, the monitor compares.
module texel_fetch_unit_tb;

    localparam int COORD_W    = 12;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 32;
    localparam int MAX_LEVELS = 4;
    localparam int LCNT_W     = $clog2(MAX_LEVELS + 1);
    localparam int BW = 10, BH = 6, BD = 5, LAYERS = 3, LEVELS = 3;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic                         req_valid = 1'b0;
    logic [2:0]                   req_kind = '0;
    logic [COORD_W-1:0]           addr_x = '0, addr_y = '0, addr_z = '0, addr_w = '0;
    logic [COORD_W-1:0]           desc_width, desc_height, desc_depth, desc_layers;
    logic [LCNT_W-1:0]            desc_levels;
    logic [MAX_LEVELS*ADDR_W-1:0] desc_level_base;
    logic                         mem_rd_en;
    logic [ADDR_W-1:0]            mem_rd_addr;
    logic [DATA_W-1:0]            mem_rd_data = '0;
    logic                         rsp_valid;
    logic [DATA_W-1:0]            rsp_data;
    logic                         rsp_err;

    int checks = 0, failures = 0, reads_seen = 0, reads_exp = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] q_data[$];
    logic              q_err[$];
    string             q_tag[$];

    always #4 clk = ~clk;

    texel_fetch_unit #(
        .COORD_W(COORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LEVELS(MAX_LEVELS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .addr_x(addr_x), .addr_y(addr_y), .addr_z(addr_z), .addr_w(addr_w),
        .desc_width(desc_width), .desc_height(desc_height), .desc_depth(desc_depth),
        .desc_layers(desc_layers), .desc_levels(desc_levels),
        .desc_level_base(desc_level_base), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    // Memory model: returns a tagged copy of the address it was given.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= {12'hC3A, mem_rd_addr};
            reads_seen  <= reads_seen + 1;
        end
    end

    function automatic int lvl_base(input int l);
        return 32'h1000 * (l + 1);
    endfunction

    function automatic int ext(input int b, input int l);
        int s = b >> l;
        return (s == 0) ? 1 : s;
    endfunction

    // Reference from the requirements: returns whether a read happens and its address.
    function automatic void model(input int k, input int x, input int y, input int z,
                                  input int w, output bit ok, output int a, output bit err);
        int lv, wl, hl, dl, cy, sl, hm, limy, lims;
        err = (k == 5);
        ok  = 1'b0;
        a   = 0;
        if (err) return;
        if (k != 0 && w >= LEVELS) return;
        lv = (k == 0) ? 0 : w;
        wl = ext(BW, lv); hl = ext(BH, lv); dl = ext(BD, lv);
        cy = 0; sl = 0; hm = 1; limy = 1; lims = 1;
        case (k)
            2, 4: begin cy = y; limy = hl; hm = hl; end
            3:    begin cy = y; sl = z; limy = hl; lims = dl; hm = hl; end
            6:    begin sl = y; lims = LAYERS; end
            7:    begin cy = y; sl = z; limy = hl; lims = LAYERS; hm = hl; end
            default: ;
        endcase
        ok = (x < wl) && (cy < limy) && (sl < lims);
        a  = lvl_base(lv) + (sl * hm + cy) * wl + x;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: presents one request for one cycle and queues the expected response.
    task automatic issue(input string tag, input int k, input int x, input int y,
                         input int z, input int w);
        bit ok, err;
        int a;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 3'(k);
        addr_x = COORD_W'(x); addr_y = COORD_W'(y);
        addr_z = COORD_W'(z); addr_w = COORD_W'(w);
        model(k, x, y, z, w, ok, a, err);
        q_data.push_back(ok ? {12'hC3A, 20'(a)} : '0);
        q_err.push_back(err);
        q_tag.push_back(tag);
        if (ok) reads_exp++;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compares each response against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_data.size() == 0) begin
                check("R11", "unexpected response", 64'd1, 64'd0);
            end else begin
                string t;
                t = q_tag.pop_front();
                check(t, "data", 64'(rsp_data), 64'(q_data.pop_front()));
                check(t, "err", 64'(rsp_err), 64'(q_err.pop_front()));
            end
        end
    end

    initial begin
        desc_width  = COORD_W'(BW);
        desc_height = COORD_W'(BH);
        desc_depth  = COORD_W'(BD);
        desc_layers = COORD_W'(LAYERS);
        desc_levels = LCNT_W'(LEVELS);
        for (int l = 0; l < MAX_LEVELS; l++)
            desc_level_base[l*ADDR_W +: ADDR_W] = ADDR_W'(lvl_base(l));

        // R12: reset state, with a request held to show it is not acted on.
        @(negedge clk);
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R12", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R12", "rsp_data in reset", 64'(rsp_data), 64'd0);
        check("R12", "rsp_err in reset", 64'(rsp_err), 64'd0);
        check("R12", "mem_rd_en in reset", 64'(mem_rd_en), 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        issue("R1 buffer in range, y z w ignored", 0, 9, 99, 77, 3);
        issue("R1 buffer x at width", 0, 10, 0, 0, 0);
        issue("R2 1D level1", 1, 4, 50, 9, 1);
        issue("R2 1D x at scaled width", 1, 5, 0, 0, 1);
        idle();
        issue("R3 2D corner, z ignored", 2, 9, 5, 100, 0);
        issue("R3 2D y at height", 2, 0, 6, 0, 0);
        issue("R7 rect level2 height floor", 4, 1, 0, 0, 2);
        issue("R7 rect level2 y beyond floor", 4, 0, 1, 0, 2);
        issue("R4 3D level1", 3, 4, 2, 1, 1);
        issue("R4 3D z at scaled depth", 3, 0, 0, 2, 1);
        issue("R7 3D level2 depth floor", 3, 1, 0, 0, 2);
        idle();
        issue("R8 2D level at count", 2, 0, 0, 0, 3);
        issue("R8 1D level beyond table", 1, 0, 0, 0, 9);
        issue("R8 2D last level", 2, 1, 0, 0, 2);
        issue("R5 1D array layer2", 6, 3, 2, 55, 0);
        issue("R5 1D array layer at count", 6, 0, 3, 0, 0);
        issue("R5 1D array layer unscaled", 6, 1, 2, 0, 2);
        issue("R6 2D array level1", 7, 1, 2, 2, 1);
        issue("R6 2D array layer at count", 7, 0, 0, 3, 0);
        issue("R9 2D x at width", 2, 10, 0, 0, 0);
        issue("R10 cube", 5, 0, 0, 0, 0);
        issue("R10 after cube", 0, 0, 0, 0, 0);
        idle();
        repeat (4) @(negedge clk);

        check("R11", "responses outstanding", 64'(q_data.size()), 64'd0);
        check("R9", "memory reads issued", 64'(reads_seen), 64'(reads_exp));
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL R11 watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule